// File: doc/BRIEF.md
# Thread-Aware Shared Pattern Direction Predictor

This block predicts the direction of conditional branches for a core that runs several hardware threads. It holds one untagged table of 2-bit saturating counters and reads it at two places for every branch. The first place is reached through an index salted with the thread number, so each thread gets its own view of the table. The second place is reached through an index that every thread computes the same way, so code that several threads run trains a common entry. A second table of 2-bit counters, addressed by the branch address alone, chooses which of the two counters decides the prediction.

Each thread keeps its own global history register, which is folded into both indices. The fetch stage drives the lookup port and reads the prediction in the same cycle. The retire stage drives the update port with the resolved outcome. An update trains both counters it addresses, moves the chooser when the two counters disagreed, and then shifts the outcome into that thread's history.

Top module: `bp_thread_pred`

## Requirements
- R1: After reset every pattern counter holds 1 (weakly not-taken), every chooser entry holds 1 (weakly prefer the shared counter) and every history register is zero, so any lookup returns lkTaken=0 and lkUsePrivate=0.
- R2: The lookup is combinational. lkTaken and lkUsePrivate reflect the table state of the current cycle. With upValid low, the update inputs change no state, whatever their values.
- R3: For thread t with history h, the shared index is pc[11:2] XOR h. The private index is that value XOR (((t+1)*423) mod 1024), which is 0x1A7 for thread 0 and 0x34E for thread 1.
- R4: A counter predicts taken when its bit 1 is set. An update moves each addressed counter one step toward the outcome and saturates at 0 and 3. An entry addressed by both indices is stepped only once.
- R5: The chooser entry is addressed by pc[11:2]. A value of 2 or more selects the private counter, and lkUsePrivate shows that selection. The entry steps toward the component that matched the outcome, saturating, and only when the two components predicted differently before the update.
- R6: An update first trains with the thread's history as it was before the update. That history then shifts left by one, and the outcome enters bit 0. The history of any other thread is unchanged.
- R7: When a lookup and an update address the same entries in one cycle, the lookup returns the values from before the update, and the update takes effect at the clock edge.
- R8: Training one thread's private entry does not change the private prediction of another thread for the same address, unless the two indices coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkTid | input | 1 | Thread issuing the lookup |
| lkPc | input | 32 | Branch address of the lookup |
| lkTaken | output | 1 | Predicted direction, 1 = taken |
| lkUsePrivate | output | 1 | 1 when the private counter decided the prediction |
| upValid | input | 1 | Update strobe |
| upTid | input | 1 | Thread of the resolved branch |
| upPc | input | 32 | Address of the resolved branch |
| upTaken | input | 1 | Resolved outcome |

## Verification
Wrong internal state becomes visible at the lookup outputs. A wrong history register shifts both indices, so the next lookup for that thread reads the wrong counters as soon as the stimulus reaches an entry whose value differs. A counter stepped in the wrong direction, or stepped twice, flips lkTaken once that entry crosses its midpoint. A chooser trained without a disagreement shows up directly on lkUsePrivate at the next lookup of that address. The random mix uses a small pool of addresses, so entries alias across threads and these errors surface within tens of updates.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef struct packed {
    logic trainPriv;
    logic trainShared;
    logic trainChooser;
    logic shiftHist;
  } bpStrobe_t;

  localparam logic [1:0] CTR_WEAK_NT     = 2'b01;
  localparam logic [1:0] CHS_WEAK_SHARED = 2'b01;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] res;
    if (up) res = (cur == 2'b11) ? cur : cur + 2'd1;
    else    res = (cur == 2'b00) ? cur : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int unsigned THREADS = 2,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned HIST_W  = 10,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PC_LSB  = 2,
  parameter int unsigned SALT    = 423,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [TID_W-1:0]          lkTid,
  input  logic [PC_W-1:0]           lkPc,
  input  logic                      upValid,
  input  logic [TID_W-1:0]          upTid,
  input  logic [PC_W-1:0]           upPc,
  input  logic                      upTaken,
  input  logic [THREADS*HIST_W-1:0] histFlat,
  input  logic [1:0]                lkPrivCtr,
  input  logic [1:0]                lkShCtr,
  input  logic [1:0]                lkChoose,
  input  logic [1:0]                upPrivCtr,
  input  logic [1:0]                upShCtr,
  input  logic [1:0]                upChoose,
  output logic [IDX_W-1:0]          lkPrivIdx,
  output logic [IDX_W-1:0]          lkShIdx,
  output logic [IDX_W-1:0]          lkChIdx,
  output logic [IDX_W-1:0]          upPrivIdx,
  output logic [IDX_W-1:0]          upShIdx,
  output logic [IDX_W-1:0]          upChIdx,
  output logic [1:0]                privNew,
  output logic [1:0]                shNew,
  output logic [1:0]                chNew,
  output bpStrobe_t                 stb,
  output logic                      lkTaken,
  output logic                      lkUsePrivate
);

  function automatic logic [IDX_W-1:0] threadSalt(input logic [TID_W-1:0] t);
    logic [31:0] prod;
    prod = (32'(t) + 32'd1) * 32'(SALT);
    return prod[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] sharedIndex(input logic [PC_W-1:0] pc,
                                                    input logic [HIST_W-1:0] h);
    return pc[PC_LSB +: IDX_W] ^ IDX_W'(h);
  endfunction

  logic [HIST_W-1:0] lkHist;
  logic [HIST_W-1:0] upHist;
  logic              upPrivPred;
  logic              upShPred;
  logic              disagree;

  always_comb begin
    lkHist = histFlat[lkTid*HIST_W +: HIST_W];
    upHist = histFlat[upTid*HIST_W +: HIST_W];
  end

  // Index generation for both ports
  always_comb begin
    lkShIdx   = sharedIndex(lkPc, lkHist);
    lkPrivIdx = lkShIdx ^ threadSalt(lkTid);
    lkChIdx   = lkPc[PC_LSB +: IDX_W];
    upShIdx   = sharedIndex(upPc, upHist);
    upPrivIdx = upShIdx ^ threadSalt(upTid);
    upChIdx   = upPc[PC_LSB +: IDX_W];
  end

  // Prediction select
  always_comb begin
    lkUsePrivate = lkChoose[1];
    lkTaken      = lkUsePrivate ? lkPrivCtr[1] : lkShCtr[1];
  end

  // Training decisions
  always_comb begin
    upPrivPred       = upPrivCtr[1];
    upShPred         = upShCtr[1];
    disagree         = upPrivPred ^ upShPred;
    privNew          = satStep(upPrivCtr, upTaken);
    shNew            = satStep(upShCtr, upTaken);
    chNew            = satStep(upChoose, upPrivPred == upTaken);
    stb.trainPriv    = upValid;
    stb.trainShared  = upValid;
    stb.trainChooser = upValid & disagree;
    stb.shiftHist    = upValid;
  end

  // R4
  counter_step_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.trainShared |-> (upTaken ? (shNew >= upShCtr) : (shNew <= upShCtr)));

  // R5
  chooser_step_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.trainChooser |-> ((upPrivCtr[1] == upTaken) ? (chNew >= upChoose) : (chNew <= upChoose)));

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int unsigned THREADS = 2,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned HIST_W  = 10,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bpStrobe_t                 stb,
  input  logic [TID_W-1:0]          upTid,
  input  logic                      upTaken,
  input  logic [IDX_W-1:0]          lkPrivIdx,
  input  logic [IDX_W-1:0]          lkShIdx,
  input  logic [IDX_W-1:0]          lkChIdx,
  input  logic [IDX_W-1:0]          upPrivIdx,
  input  logic [IDX_W-1:0]          upShIdx,
  input  logic [IDX_W-1:0]          upChIdx,
  input  logic [1:0]                privNew,
  input  logic [1:0]                shNew,
  input  logic [1:0]                chNew,
  output logic [THREADS*HIST_W-1:0] histFlat,
  output logic [1:0]                lkPrivCtr,
  output logic [1:0]                lkShCtr,
  output logic [1:0]                lkChoose,
  output logic [1:0]                upPrivCtr,
  output logic [1:0]                upShCtr,
  output logic [1:0]                upChoose
);

  logic [1:0]        ctrTbl [ENTRIES];
  logic [1:0]        chTbl  [ENTRIES];
  logic [HIST_W-1:0] hist   [THREADS];

  always_comb begin
    lkPrivCtr = ctrTbl[lkPrivIdx];
    lkShCtr   = ctrTbl[lkShIdx];
    lkChoose  = chTbl[lkChIdx];
    upPrivCtr = ctrTbl[upPrivIdx];
    upShCtr   = ctrTbl[upShIdx];
    upChoose  = chTbl[upChIdx];
    for (int t = 0; t < THREADS; t++) histFlat[t*HIST_W +: HIST_W] = hist[t];
  end

  // Pattern counters: a shared entry hit by both indices gets the same value twice
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) ctrTbl[i] <= CTR_WEAK_NT;
    end else begin
      if (stb.trainPriv)   ctrTbl[upPrivIdx] <= privNew;
      if (stb.trainShared) ctrTbl[upShIdx]   <= shNew;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) chTbl[i] <= CHS_WEAK_SHARED;
    end else if (stb.trainChooser) begin
      chTbl[upChIdx] <= chNew;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < THREADS; t++) hist[t] <= '0;
    end else if (stb.shiftHist) begin
      for (int t = 0; t < THREADS; t++)
        if (upTid == TID_W'(t)) hist[t] <= {hist[t][HIST_W-2:0], upTaken};
    end
  end

  // R2
  lookup_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stb.trainPriv) && !$past(stb.trainShared) && $stable(lkShIdx)) |-> $stable(lkShCtr));

  generate
    for (genvar g = 0; g < THREADS; g++) begin : g_histChk
      // R6
      other_hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && (!$past(stb.shiftHist) || $past(upTid) != TID_W'(g))) |-> $stable(hist[g]));
    end
  endgenerate

endmodule

// File: rtl/bp_thread_pred.sv
module bp_thread_pred
  import bp_pkg::*;
#(
  parameter int unsigned THREADS = 2,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned HIST_W  = 10,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PC_LSB  = 2,
  parameter int unsigned SALT    = 423,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TID_W-1:0] lkTid,
  input  logic [PC_W-1:0]  lkPc,
  output logic             lkTaken,
  output logic             lkUsePrivate,
  input  logic             upValid,
  input  logic [TID_W-1:0] upTid,
  input  logic [PC_W-1:0]  upPc,
  input  logic             upTaken
);

  bpStrobe_t                 stb;
  logic [THREADS*HIST_W-1:0] histFlat;
  logic [IDX_W-1:0]          lkPrivIdx, lkShIdx, lkChIdx;
  logic [IDX_W-1:0]          upPrivIdx, upShIdx, upChIdx;
  logic [1:0]                lkPrivCtr, lkShCtr, lkChoose;
  logic [1:0]                upPrivCtr, upShCtr, upChoose;
  logic [1:0]                privNew, shNew, chNew;

  bp_ctrl #(
    .THREADS(THREADS), .IDX_W(IDX_W), .HIST_W(HIST_W),
    .PC_W(PC_W), .PC_LSB(PC_LSB), .SALT(SALT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .lkTid(lkTid), .lkPc(lkPc),
    .upValid(upValid), .upTid(upTid), .upPc(upPc), .upTaken(upTaken),
    .histFlat(histFlat),
    .lkPrivCtr(lkPrivCtr), .lkShCtr(lkShCtr), .lkChoose(lkChoose),
    .upPrivCtr(upPrivCtr), .upShCtr(upShCtr), .upChoose(upChoose),
    .lkPrivIdx(lkPrivIdx), .lkShIdx(lkShIdx), .lkChIdx(lkChIdx),
    .upPrivIdx(upPrivIdx), .upShIdx(upShIdx), .upChIdx(upChIdx),
    .privNew(privNew), .shNew(shNew), .chNew(chNew),
    .stb(stb), .lkTaken(lkTaken), .lkUsePrivate(lkUsePrivate)
  );

  bp_datapath #(
    .THREADS(THREADS), .IDX_W(IDX_W), .HIST_W(HIST_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .upTid(upTid), .upTaken(upTaken),
    .lkPrivIdx(lkPrivIdx), .lkShIdx(lkShIdx), .lkChIdx(lkChIdx),
    .upPrivIdx(upPrivIdx), .upShIdx(upShIdx), .upChIdx(upChIdx),
    .privNew(privNew), .shNew(shNew), .chNew(chNew),
    .histFlat(histFlat),
    .lkPrivCtr(lkPrivCtr), .lkShCtr(lkShCtr), .lkChoose(lkChoose),
    .upPrivCtr(upPrivCtr), .upShCtr(upShCtr), .upChoose(upChoose)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!lkTaken && !lkUsePrivate));

endmodule

// File: tb/bp_thread_pred_tb_top.sv
`timescale 1ns/1ps
module bp_thread_pred_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkTid = 1'b0;
  logic [31:0] lkPc = '0;
  logic        lkTaken;
  logic        lkUsePrivate;
  logic        upValid = 1'b0;
  logic        upTid = 1'b0;
  logic [31:0] upPc = '0;
  logic        upTaken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [1:0] mCtr  [1024];
  logic [1:0] mCh   [1024];
  logic [9:0] mHist [2];

  always #10 clk = ~clk;

  bp_thread_pred dut_i (
    .clk(clk), .rstN(rstN),
    .lkTid(lkTid), .lkPc(lkPc), .lkTaken(lkTaken), .lkUsePrivate(lkUsePrivate),
    .upValid(upValid), .upTid(upTid), .upPc(upPc), .upTaken(upTaken)
  );

  function automatic logic [1:0] modelStep(input logic [1:0] c, input bit up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic [9:0] mShIdx(input bit t, input logic [31:0] pc);
    return pc[11:2] ^ mHist[t];
  endfunction

  function automatic logic [9:0] mPrIdx(input bit t, input logic [31:0] pc);
    return mShIdx(t, pc) ^ (t ? 10'h34E : 10'h1A7);
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit lt, input logic [31:0] lp, input bit uv, input bit ut,
                      input logic [31:0] up, input bit tk, input string tag);
    logic [9:0] ip, is, ci;
    bit pp, sp, usePr, expT;
    @(negedge clk);
    lkTid = lt; lkPc = lp; upValid = uv; upTid = ut; upPc = up; upTaken = tk;
    #1;
    usePr = mCh[lp[11:2]][1];
    expT  = usePr ? mCtr[mPrIdx(lt, lp)][1] : mCtr[mShIdx(lt, lp)][1];
    check(tag, "lkTaken", lkTaken, expT);
    check(tag, "lkUsePrivate", lkUsePrivate, usePr);
    if (uv) begin
      ip = mPrIdx(ut, up);
      is = mShIdx(ut, up);
      ci = up[11:2];
      pp = mCtr[ip][1];
      sp = mCtr[is][1];
      begin
        logic [1:0] nIp, nIs;
        nIp = modelStep(mCtr[ip], tk);
        nIs = modelStep(mCtr[is], tk);
        mCtr[ip] = nIp;
        mCtr[is] = nIs;
      end
      if (pp != sp) mCh[ci] = modelStep(mCh[ci], pp == tk);
      mHist[ut] = {mHist[ut][8:0], tk};
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [31:0] pool [8];

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin mCtr[i] = 2'd1; mCh[i] = 2'd1; end
    mHist[0] = '0; mHist[1] = '0;
    for (int i = 0; i < 8; i++) pool[i] = {$urandom} & 32'h0000_0FFC;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1: reset state seen through lookups on both threads
    step(0, 32'h0000_0100, 0, 0, 0, 0, "R1");
    step(1, 32'h0000_0ABC, 0, 0, 0, 0, "R1");

    // R7: lookup and update on the same entries in one cycle return old values
    step(0, 32'h0000_0040, 1, 0, 32'h0000_0040, 1, "R7");
    step(0, 32'h0000_0040, 1, 0, 32'h0000_0040, 1, "R7");

    // R2: update inputs toggle while upValid is low; nothing may move
    for (int i = 0; i < 20; i++)
      step(i[0], pool[i % 8], 0, ~i[0], {$urandom} & 32'hFFC, i[1], "R2");

    // R4: drive thread 1 into saturation on one address, then reverse
    for (int i = 0; i < 14; i++) step(1, 32'h0000_0200, 1, 1, 32'h0000_0200, 1, "R4");
    for (int i = 0; i < 4; i++)  step(1, 32'h0000_0200, 1, 1, 32'h0000_0200, 0, "R4");

    // R8: thread 0 trains an address, thread 1 looks it up
    for (int i = 0; i < 12; i++) step(1, 32'h0000_0300, 1, 0, 32'h0000_0300, 1, "R8");
    step(1, 32'h0000_0300, 0, 0, 0, 0, "R8");

    // R6: alternating threads with opposite outcomes keep histories apart
    for (int i = 0; i < 16; i++)
      step(~i[0], pool[i % 4], 1, i[0], pool[i % 4], i[0], "R6");

    // R3 R5: mixed random traffic over a small aliasing address pool
    for (int i = 0; i < 4000; i++) begin
      bit lt, ut, uv, tk;
      logic [31:0] lp, up;
      lt = 1'($urandom);
      ut = 1'($urandom);
      uv = ($urandom % 4) != 0;
      tk = ($urandom % 3) != 0;
      lp = ($urandom % 5 == 0) ? ({$urandom} & 32'hFFFF_FFFC) : pool[$urandom % 8];
      up = ($urandom % 5 == 0) ? ({$urandom} & 32'hFFFF_FFFC) : pool[$urandom % 8];
      step(lt, lp, uv, ut, up, tk, "R3 R5");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule